// File: doc/BRIEF.md
# Control-Transfer Instruction Decoder

This block takes a 32-bit MIPS-style instruction word and turns it into the control flags that next-PC selection and writeback need for branches and jumps. It is purely combinational. It looks at three fields of the word:

- the primary opcode, which selects the instruction group;
- the 5-bit sub-selector of the register-immediate group, which picks among the sign-test branches;
- the function field of the register group, which picks the register jumps.

Conditional branches are not given individual condition codes. Each one is described by three things: a base comparison (equality, less-than-zero, or less-or-equal-zero), a single invert flag, and flags naming the operands it reads.

For linking instructions the block also marks the register write. The link value, the instruction address plus 8, takes the place of the second operand, and the ALU passes that operand through unchanged. The block reports which register receives the write.

Every encoding this block does not recognise produces all flags low, including the supported flag. Arithmetic decode is out of scope for this block, so it also reports supported low for arithmetic instructions; a downstream decoder handles those.

Top module: `brj_decode`

## Requirements
- R1: With opcode bits 31:26 equal to 1, the sub-selector is bits 20:16. Value 0 gives branch, rs-required and supported. Value 1 gives the same three plus invert. Neither value sets the less-or-equal selector, rt-required, jump or any write.
- R2: In the opcode-1 group, sub-selector 16 decodes like value 0 and sub-selector 17 decodes like value 1. Both also set register-write and link-to-r31, and the destination is 31.
- R3: In the opcode-1 group, sub-selector values 2, 3, 18 and 19, the trap values 8 to 12 and 14, and every other value not named in R1, R2 or R4 give all flags low, including supported.
- R4: In the opcode-1 group, sub-selector 31 gives supported and rs-required only. Branch and jump stay low.
- R5: Opcode 4 gives branch, rs-required, rt-required and supported. Opcode 5 gives the same four plus invert.
- R6: Opcode 6 gives branch, the less-or-equal selector, rs-required and supported. Opcode 7 gives the same four plus invert.
- R7: Opcode 2 gives jump and supported only. Opcode 3 gives jump, register-write, link-to-r31 and supported.
- R8: With opcode 0, function bits 5:0 equal to 8 give jump, rs-required and supported. Function value 9 gives the same three plus register-write and link-to-rd.
- R9: The destination index is 31 when link-to-r31 is set. Otherwise it is bits 15:11 when link-to-rd is set, and bits 20:16 in all other cases.
- R10: Every other opcode, and opcode 0 with any function value other than 8 or 9, gives all flags low.
- R11: Branch and jump are never high together. The outputs depend only on the current instruction word and follow it within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| is_branch_o | output | 1 | Conditional branch |
| is_jump_o | output | 1 | Unconditional jump |
| cond_inv_o | output | 1 | Invert the base comparison |
| cond_lez_o | output | 1 | Use less-or-equal-zero instead of less-than-zero |
| need_rs_o | output | 1 | Reads the first source register |
| need_rt_o | output | 1 | Reads the second source register |
| link_ra_o | output | 1 | Write the link value to register 31 |
| link_rd_o | output | 1 | Write the link value to the rd field register |
| reg_wr_o | output | 1 | Register write enable |
| supported_o | output | 1 | Encoding recognised by this block |
| dest_o | output | 5 | Destination register index |

## Verification
The block holds no state, so any wrong sub-decode result shows up at the ports in the same cycle the word is applied. A swapped group table or a wrong case item shows up as a wrong flag vector for one specific encoding. For that reason the bench sweeps every opcode, every sub-selector value of the register-immediate group and every function value of the register group, and compares each result against a model built from the requirements. A destination mux fault shows up only on linking or R-type words, so those are driven with distinct rd and rt fields.

// File: rtl/brj_pkg.sv
package brj_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 6;
  localparam int REG_W  = 5;
  localparam int FN_W   = 6;

  localparam int OP_LSB = 26;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int FN_LSB = 0;

  localparam logic [OP_W-1:0] OP_RTYPE  = 6'd0;
  localparam logic [OP_W-1:0] OP_SIGNBR = 6'd1;
  localparam logic [OP_W-1:0] OP_JUMP   = 6'd2;
  localparam logic [OP_W-1:0] OP_JLINK  = 6'd3;
  localparam logic [OP_W-1:0] OP_EQ     = 6'd4;
  localparam logic [OP_W-1:0] OP_NE     = 6'd5;
  localparam logic [OP_W-1:0] OP_LEZ    = 6'd6;
  localparam logic [OP_W-1:0] OP_GTZ    = 6'd7;

  localparam logic [FN_W-1:0] FN_JREG   = 6'd8;
  localparam logic [FN_W-1:0] FN_JRLINK = 6'd9;

  typedef struct packed {
    logic br;
    logic jmp;
    logic inv;
    logic lez;
    logic need_rs;
    logic need_rt;
    logic link_ra;
    logic link_rd;
    logic wr;
    logic ok;
  } ctl_t;

  localparam ctl_t CTL_NONE = '0;
endpackage

// File: rtl/brj_signbr_dec.sv
module brj_signbr_dec
  import brj_pkg::*;
#(
  parameter int SEL_W = REG_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output ctl_t             ctl_o
);
  localparam logic [SEL_W-1:0] SEL_LT    = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_GE    = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_LTL   = SEL_W'(16);
  localparam logic [SEL_W-1:0] SEL_GEL   = SEL_W'(17);
  localparam logic [SEL_W-1:0] SEL_CSYNC = SEL_W'(31);

  always_comb begin
    ctl_o = CTL_NONE;
    unique case (sel_i)
      SEL_LT, SEL_GE, SEL_LTL, SEL_GEL: begin
        ctl_o.br      = 1'b1;
        ctl_o.need_rs = 1'b1;
        ctl_o.ok      = 1'b1;
        ctl_o.inv     = sel_i[0];
        ctl_o.link_ra = sel_i[4];
        ctl_o.wr      = sel_i[4];
      end
      SEL_CSYNC: begin
        ctl_o.need_rs = 1'b1;
        ctl_o.ok      = 1'b1;
      end
      default: ctl_o = CTL_NONE;
    endcase
  end
endmodule

// File: rtl/brj_funct_dec.sv
module brj_funct_dec
  import brj_pkg::*;
(
  input  logic [FN_W-1:0] fn_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o = CTL_NONE;
    unique case (fn_i)
      FN_JREG, FN_JRLINK: begin
        ctl_o.jmp     = 1'b1;
        ctl_o.need_rs = 1'b1;
        ctl_o.ok      = 1'b1;
        ctl_o.link_rd = (fn_i == FN_JRLINK);
        ctl_o.wr      = (fn_i == FN_JRLINK);
      end
      default: ctl_o = CTL_NONE;
    endcase
  end
endmodule

// File: rtl/brj_major_dec.sv
module brj_major_dec
  import brj_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  ctl_t            signbr_i,
  input  ctl_t            funct_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o = CTL_NONE;
    unique case (op_i)
      OP_RTYPE:  ctl_o = funct_i;
      OP_SIGNBR: ctl_o = signbr_i;
      OP_JUMP, OP_JLINK: begin
        ctl_o.jmp     = 1'b1;
        ctl_o.ok      = 1'b1;
        ctl_o.link_ra = op_i[0];
        ctl_o.wr      = op_i[0];
      end
      OP_EQ, OP_NE, OP_LEZ, OP_GTZ: begin
        ctl_o.br      = 1'b1;
        ctl_o.need_rs = 1'b1;
        ctl_o.ok      = 1'b1;
        ctl_o.inv     = op_i[0];
        ctl_o.lez     = op_i[1];
        ctl_o.need_rt = ~op_i[1];
      end
      default: ctl_o = CTL_NONE;
    endcase
  end
endmodule

// File: rtl/brj_decode.sv
module brj_decode
  import brj_pkg::*;
#(
  parameter int          DEST_W   = REG_W,
  parameter logic [4:0]  LINK_REG = 5'd31
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic              is_branch_o,
  output logic              is_jump_o,
  output logic              cond_inv_o,
  output logic              cond_lez_o,
  output logic              need_rs_o,
  output logic              need_rt_o,
  output logic              link_ra_o,
  output logic              link_rd_o,
  output logic              reg_wr_o,
  output logic              supported_o,
  output logic [DEST_W-1:0] dest_o
);
  logic [OP_W-1:0]   op_f;
  logic [REG_W-1:0]  rt_f;
  logic [REG_W-1:0]  rd_f;
  logic [FN_W-1:0]   fn_f;
  logic              unused_fields;
  ctl_t              signbr_ctl, funct_ctl, ctl;

  assign op_f = insn_i[OP_LSB +: OP_W];
  assign rt_f = insn_i[RT_LSB +: REG_W];
  assign rd_f = insn_i[RD_LSB +: REG_W];
  assign fn_f = insn_i[FN_LSB +: FN_W];
  assign unused_fields = ^{insn_i[25:21], insn_i[10:6]};

  brj_signbr_dec #(.SEL_W(REG_W)) u_signbr (
    .sel_i (rt_f),
    .ctl_o (signbr_ctl)
  );

  brj_funct_dec u_funct (
    .fn_i  (fn_f),
    .ctl_o (funct_ctl)
  );

  brj_major_dec u_major (
    .op_i     (op_f),
    .signbr_i (signbr_ctl),
    .funct_i  (funct_ctl),
    .ctl_o    (ctl)
  );

  always_comb begin
    if (ctl.link_ra)      dest_o = DEST_W'(LINK_REG);
    else if (ctl.link_rd) dest_o = DEST_W'(rd_f);
    else                  dest_o = DEST_W'(rt_f);
  end

  assign is_branch_o = ctl.br;
  assign is_jump_o   = ctl.jmp;
  assign cond_inv_o  = ctl.inv;
  assign cond_lez_o  = ctl.lez;
  assign need_rs_o   = ctl.need_rs;
  assign need_rt_o   = ctl.need_rt;
  assign link_ra_o   = ctl.link_ra;
  assign link_rd_o   = ctl.link_rd;
  assign reg_wr_o    = ctl.wr;
  assign supported_o = ctl.ok;

  always_comb begin
    AST_BR_JMP_EXCL: assert (!(is_branch_o && is_jump_o)); // R11
    AST_UNSUP_QUIET: assert (supported_o || !(is_branch_o || is_jump_o || reg_wr_o || need_rs_o)); // R10
    AST_LINK_WRITES: assert (!(link_ra_o || link_rd_o) || reg_wr_o); // R2
    AST_LINK_RA_DEST: assert (!link_ra_o || dest_o == DEST_W'(LINK_REG)); // R9
    AST_RT_ONLY_EQ: assert (!need_rt_o || (is_branch_o && !cond_lez_o)); // R5
    AST_JALR_RD: assert (!link_rd_o || (is_jump_o && op_f == OP_RTYPE)); // R8
  end
endmodule

// File: tb/brj_decode_test.sv
module brj_decode_test;
  logic        clk;
  logic [31:0] insn;
  logic        br, jp, inv, lez, nrs, nrt, lra, lrd, wr, ok;
  logic [4:0]  dest;

  typedef struct {
    logic [31:0] word;
    logic [14:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  brj_decode uut (
    .insn_i(insn), .is_branch_o(br), .is_jump_o(jp), .cond_inv_o(inv),
    .cond_lez_o(lez), .need_rs_o(nrs), .need_rt_o(nrt), .link_ra_o(lra),
    .link_rd_o(lrd), .reg_wr_o(wr), .supported_o(ok), .dest_o(dest)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // expected vector {br,jmp,inv,lez,rs,rt,lra,lrd,wr,ok,dest[4:0]} from requirements
  function automatic logic [14:0] model(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] rt = w[20:16];
    logic [4:0] rd = w[15:11];
    logic [5:0] fn = w[5:0];
    logic [9:0] f = '0;
    logic [4:0] d;
    case (op)
      6'd0: if (fn == 6'd8) f = 10'b0100100001;
            else if (fn == 6'd9) f = 10'b0100100111;
      6'd1: case (rt)
              5'd0:  f = 10'b1000100001;
              5'd1:  f = 10'b1010100001;
              5'd16: f = 10'b1000101011;
              5'd17: f = 10'b1010101011;
              5'd31: f = 10'b0000100001;
              default: f = '0;
            endcase
      6'd2: f = 10'b0100000001;
      6'd3: f = 10'b0100001011;
      6'd4: f = 10'b1000110001;
      6'd5: f = 10'b1010110001;
      6'd6: f = 10'b1001100001;
      6'd7: f = 10'b1011100001;
      default: f = '0;
    endcase
    d = f[3] ? 5'd31 : (f[2] ? rd : rt);
    return {f, d};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:26])
      6'd0: return (w[5:0] == 6'd8 || w[5:0] == 6'd9) ? "R8" : "R10";
      6'd1: case (w[20:16])
              5'd0, 5'd1:   return "R1";
              5'd16, 5'd17: return "R2";
              5'd31:        return "R4";
              default:      return "R3";
            endcase
      6'd2, 6'd3: return "R7";
      6'd4, 6'd5: return "R5";
      6'd6, 6'd7: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    insn = w;
    it.word = w;
    it.exp  = model(w);
    it.tag  = tag;
    q.push_back(it);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [5:0] fn);
    return {op, 5'd7, rt, rd, 5'd3, fn};
  endfunction

  // monitor: pops expected items and compares away from the driving edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [14:0] act;
      it  = q.pop_front();
      act = {br, jp, inv, lez, nrs, nrt, lra, lrd, wr, ok, dest};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s word=%h actual=%b expected=%b", it.tag, it.word, act, it.exp);
      end
      if (!(br && jp)) ; else begin
        fails++;
        $display("FAIL R11 word=%h actual=br&jmp expected=exclusive", it.word);
      end
    end
  end

  initial begin
    insn = '0;
    drive(32'h0, "R10");                           // idle word: all low
    drive(mk(6'd1, 5'd0, 5'd4, 6'd0), "R1");       // sign < 0
    drive(mk(6'd1, 5'd1, 5'd4, 6'd0), "R1");       // sign >= 0
    drive(mk(6'd1, 5'd16, 5'd4, 6'd0), "R2");      // linking, dest 31
    drive(mk(6'd1, 5'd17, 5'd4, 6'd0), "R2");
    drive(mk(6'd1, 5'd2, 5'd4, 6'd0), "R3");       // likely variant
    drive(mk(6'd1, 5'd19, 5'd4, 6'd0), "R3");
    drive(mk(6'd1, 5'd12, 5'd4, 6'd0), "R3");      // trap immediate
    drive(mk(6'd1, 5'd31, 5'd4, 6'd0), "R4");
    drive(mk(6'd4, 5'd9, 5'd4, 6'd0), "R5");
    drive(mk(6'd5, 5'd9, 5'd4, 6'd0), "R5");
    drive(mk(6'd6, 5'd0, 5'd4, 6'd0), "R6");
    drive(mk(6'd7, 5'd0, 5'd4, 6'd0), "R6");
    drive(32'h0812_3456, "R7");                    // plain jump, dest = rt bits
    drive(32'h0C12_3456, "R7");                    // jump and link
    drive(mk(6'd0, 5'd5, 5'd22, 6'd8), "R8");
    drive(mk(6'd0, 5'd5, 5'd22, 6'd9), "R9");      // dest from rd, not rt
    drive(mk(6'd0, 5'd5, 5'd31, 6'd9), "R9");
    drive(mk(6'd8, 5'd5, 5'd22, 6'd0), "R10");
    for (int o = 0; o < 64; o++) drive(mk(o[5:0], 5'd13, 5'd26, 6'd9), tag_of(mk(o[5:0], 5'd13, 5'd26, 6'd9)));
    for (int r = 0; r < 32; r++) drive(mk(6'd1, r[4:0], 5'd2, 6'd0), tag_of(mk(6'd1, r[4:0], 5'd2, 6'd0)));
    for (int f = 0; f < 64; f++) drive(mk(6'd0, 5'd6, 5'd14, f[5:0]), tag_of(mk(6'd0, 5'd6, 5'd14, f[5:0])));
    for (int k = 0; k < 40; k++) begin             // R11: back-to-back changes follow in same cycle
      logic [31:0] w = {k[5:0] ^ 6'h2a, k[4:0] * 5'd7, k[4:0], 10'h155, k[5:0] + 6'd5};
      drive(w, "R11");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule